// File: doc/BRIEF.md
# Instruction Class and Operand Predecoder

This block sits just behind instruction fetch in a fixed/floating-point DSP core. Each accepted 32-bit instruction word, together with the word address it was fetched from, passes through one register stage. On the way it is split into an instruction class, a source addressing mode, the raw register and indirect-address fields, and both extensions of the 16-bit immediate. Two special cases are recognised: the data-page load form and the parallel-store routing fields. For branch words the block adds a branch sub-kind, a trap vector and a decrement-register index. Where one exists, it also gives the resolved target word address, absolute or PC-relative.

Decoded fields are given raw wherever the consumer picks them by class. Class-specific outputs (branch kind, target, trap vector, decrement register, parallel-store routing) are forced to zero outside their class. The input and output are a valid/ready stream pair. The stage accepts a word whenever its output slot is empty or is being drained in the same cycle. A stalled output holds every field steady until it is taken.

Top module: `instr_predecoder`

## Requirements
- R1: The class output is computed from the instruction word as follows. When bit 31 is 1, bits 31:30 = 10 gives code 3 (parallel multiply/add) and 11 gives code 4 (parallel store). When bit 31 is 0, bits 31:29 = 000 or 010 gives code 0 (two-operand), 001 gives code 1 (three-operand) and 011 gives code 2 (branch).
- R2: The addressing mode output equals word bits 22:21 (00 register, 01 direct, 10 indirect, 11 immediate). The destination register output equals bits 20:16 and the source register output equals bits 4:0, for every class.
- R3: The immediate is bits 15:0. It is given zero-extended on one output and sign-extended from bit 15 on another, both IMM_W bits wide.
- R4: The wide indirect operand fields are a modifier from bits 15:11, an auxiliary register from bits 10:8 and a displacement from bits 7:0.
- R5: Two short indirect operands are given. The low one has modifier bits 7:3 and register bits 2:0. The high one has modifier bits 15:11 and register bits 10:8.
- R6: The page-load flag is 1 exactly when bits 31:8 equal 0x087000. In that case the page value is the low byte shifted left by 16 (24 bits); otherwise the page value is 0.
- R7: The branch kind is 0 for any non-branch class. For a branch it is taken from bits 28:26: 000/001 give 1 (absolute), 010 gives 2 (conditional), 011 gives 3 (decrement-and-branch), 100/101 give 4 (trap) and 110/111 give 5 (other).
- R8: An absolute branch has a valid target equal to bits 23:0.
- R9: A conditional or decrement-and-branch word with bit 25 set has a valid target equal to PC + 1 + sign-extended bits 15:0, plus 2 more when bit 21 is set, modulo 2^PC_W. The target-valid flag is 0 and the target is 0 for every other word.
- R10: The trap vector equals bits 4:0 for trap kind and 0 otherwise. The decrement register index equals bits 24:22 for decrement-and-branch and 0 otherwise.
- R11: For the parallel-store class, the routing output is bits 25:24. The first destination is R0 or R1 (value 0 or 1) by bit 23, and the second is R2 or R3 (value 2 or 3) by bit 22. All three are 0 for other classes.
- R12: The input ready signal equals (not output valid) or output ready. A word accepted at an edge makes the output valid right after that edge. While the output is valid and not ready, the output stays valid and every field holds.
- R13: A synchronous reset clears the output valid at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_word | input | 32 | Instruction word |
| in_pc | input | PC_W | Word address of the instruction |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_cls | output | 3 | Instruction class code |
| out_amode | output | 2 | Source addressing mode |
| out_dst_reg | output | 5 | Destination register number |
| out_src_reg | output | 5 | Source register number |
| out_imm_zext | output | IMM_W | Immediate, zero-extended |
| out_imm_sext | output | IMM_W | Immediate, sign-extended |
| out_ind_mod | output | 5 | Wide indirect modifier |
| out_ind_ar | output | 3 | Wide indirect auxiliary register |
| out_ind_disp | output | 8 | Wide indirect displacement |
| out_lo_mod | output | 5 | Low short indirect modifier |
| out_lo_ar | output | 3 | Low short indirect register |
| out_hi_mod | output | 5 | High short indirect modifier |
| out_hi_ar | output | 3 | High short indirect register |
| out_page_load | output | 1 | Data-page load detected |
| out_page_val | output | 24 | Data-page value |
| out_par_route | output | 2 | Parallel-store routing select |
| out_par_dst_a | output | 2 | First parallel destination register |
| out_par_dst_b | output | 2 | Second parallel destination register |
| out_br_kind | output | 3 | Branch sub-kind |
| out_trap_vec | output | 5 | Trap vector |
| out_dec_ar | output | 3 | Decrement-and-branch register |
| out_tgt_valid | output | 1 | Branch target valid |
| out_tgt | output | PC_W | Branch target word address |

## Verification
The stage has only one register level, so any wrong decode appears in the cycle right after the word is accepted. It shows up as a field that differs from the arithmetic expectation for that word. Gating mistakes show up as nonzero class-specific outputs on words of another class. Target arithmetic faults show at the sign boundary of the offset, with the delayed flag, and where the address wraps. A broken hold or ready path shows as a field changing, or a second word being lost, during a stall.

// File: rtl/pdec_pkg.sv
`timescale 1ns/1ps
package pdec_pkg;
  localparam int WORD_W  = 32;
  localparam int REG_W   = 5;
  localparam int AR_W    = 3;
  localparam int MOD_W   = 5;
  localparam int DISP_W  = 8;
  localparam int HALF_W  = 16;
  localparam int ABS_W   = 24;
  localparam int PAGE_W  = 24;
  localparam int VEC_W   = 5;
  localparam logic [23:0] PAGE_LOAD_KEY = 24'h087000;

  typedef enum logic [2:0] {
    CLS_TWO_OP    = 3'd0,
    CLS_THREE_OP  = 3'd1,
    CLS_BRANCH    = 3'd2,
    CLS_PAR_MAC   = 3'd3,
    CLS_PAR_STORE = 3'd4
  } iclass_e;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_ABS   = 3'd1,
    BK_COND  = 3'd2,
    BK_DEC   = 3'd3,
    BK_TRAP  = 3'd4,
    BK_OTHER = 3'd5
  } brkind_e;

  typedef struct packed {
    logic [MOD_W-1:0] modf;
    logic [AR_W-1:0]  ar;
  } ind_short_t;
endpackage

// File: rtl/pdec_class.sv
`timescale 1ns/1ps
module pdec_class
  import pdec_pkg::*;
(
  input  logic [2:0] prefix,
  output iclass_e    cls
);
  // Variable-width prefix: two bits when the top bit is set, three otherwise.
  always_comb begin
    if (prefix[2]) begin
      cls = prefix[1] ? CLS_PAR_STORE : CLS_PAR_MAC;
    end else begin
      unique case (prefix[1:0])
        2'b01:   cls = CLS_THREE_OP;
        2'b11:   cls = CLS_BRANCH;
        default: cls = CLS_TWO_OP;
      endcase
    end
  end
endmodule

// File: rtl/pdec_operand.sv
`timescale 1ns/1ps
module pdec_operand
  import pdec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              is_par_store,
  output logic [1:0]        amode,
  output logic [REG_W-1:0]  dst_reg,
  output logic [REG_W-1:0]  src_reg,
  output logic [IMM_W-1:0]  imm_zext,
  output logic [IMM_W-1:0]  imm_sext,
  output logic [MOD_W-1:0]  ind_mod,
  output logic [AR_W-1:0]   ind_ar,
  output logic [DISP_W-1:0] ind_disp,
  output ind_short_t        lo_ind,
  output ind_short_t        hi_ind,
  output logic              page_load,
  output logic [PAGE_W-1:0] page_val,
  output logic [1:0]        par_route,
  output logic [1:0]        par_dst_a,
  output logic [1:0]        par_dst_b
);
  localparam int IMM_PAD = IMM_W - HALF_W;
  logic [HALF_W-1:0] half;

  assign half     = word[HALF_W-1:0];
  assign amode    = word[22:21];
  assign dst_reg  = word[20:16];
  assign src_reg  = word[REG_W-1:0];

  generate
    if (IMM_PAD > 0) begin : g_imm_wide
      assign imm_zext = {{IMM_PAD{1'b0}}, half};
      assign imm_sext = {{IMM_PAD{half[HALF_W-1]}}, half};
    end else begin : g_imm_exact
      assign imm_zext = half;
      assign imm_sext = half;
    end
  endgenerate

  // Wide indirect operand occupies the whole low half.
  assign ind_mod  = half[15:11];
  assign ind_ar   = half[10:8];
  assign ind_disp = half[7:0];

  // Two packed short indirect operands, one per byte.
  assign lo_ind.modf = half[7:3];
  assign lo_ind.ar   = half[2:0];
  assign hi_ind.modf = half[15:11];
  assign hi_ind.ar   = half[10:8];

  assign page_load = (word[WORD_W-1:8] == PAGE_LOAD_KEY);
  assign page_val  = page_load ? {word[7:0], 16'h0000} : '0;

  always_comb begin
    par_route = 2'b00;
    par_dst_a = 2'b00;
    par_dst_b = 2'b00;
    if (is_par_store) begin
      par_route = word[25:24];
      par_dst_a = {1'b0, word[23]};
      par_dst_b = {1'b1, word[22]};
    end
  end
endmodule

// File: rtl/pdec_branch.sv
`timescale 1ns/1ps
module pdec_branch
  import pdec_pkg::*;
#(
  parameter int PC_W = 24
) (
  input  logic [28:0]      bits,
  input  logic [PC_W-1:0]  pc,
  input  logic             is_branch,
  output brkind_e          kind,
  output logic             tgt_valid,
  output logic [PC_W-1:0]  tgt,
  output logic [VEC_W-1:0] trap_vec,
  output logic [AR_W-1:0]  dec_ar
);
  localparam int OFF_PAD = PC_W - HALF_W;
  localparam int ABS_PAD = PC_W - ABS_W;

  logic            pcrel, delayed;
  logic [PC_W-1:0] off_ext, abs_tgt, rel_tgt, slot_adj;

  assign pcrel   = bits[25];
  assign delayed = bits[21];

  generate
    if (OFF_PAD > 0) begin : g_off_ext
      assign off_ext = {{OFF_PAD{bits[15]}}, bits[15:0]};
    end else begin : g_off_raw
      assign off_ext = bits[15:0];
    end
    if (ABS_PAD > 0) begin : g_abs_ext
      assign abs_tgt = {{ABS_PAD{1'b0}}, bits[23:0]};
    end else if (ABS_PAD == 0) begin : g_abs_raw
      assign abs_tgt = bits[23:0];
    end else begin : g_abs_trunc
      assign abs_tgt = bits[PC_W-1:0];
    end
  endgenerate

  // Delayed branches skip the slot instructions that follow.
  assign slot_adj = delayed ? PC_W'(3) : PC_W'(1);
  assign rel_tgt  = pc + slot_adj + off_ext;

  always_comb begin
    kind = BK_NONE;
    if (is_branch) begin
      unique case (bits[28:26])
        3'b000, 3'b001: kind = BK_ABS;
        3'b010:         kind = BK_COND;
        3'b011:         kind = BK_DEC;
        3'b100, 3'b101: kind = BK_TRAP;
        default:        kind = BK_OTHER;
      endcase
    end
  end

  always_comb begin
    tgt_valid = 1'b0;
    tgt       = '0;
    unique case (kind)
      BK_ABS: begin
        tgt_valid = 1'b1;
        tgt       = abs_tgt;
      end
      BK_COND, BK_DEC: begin
        tgt_valid = pcrel;
        tgt       = pcrel ? rel_tgt : '0;
      end
      default: ;
    endcase
  end

  assign trap_vec = (kind == BK_TRAP) ? bits[VEC_W-1:0] : '0;
  assign dec_ar   = (kind == BK_DEC)  ? bits[24:22]     : '0;
endmodule

// File: rtl/instr_predecoder.sv
`timescale 1ns/1ps
module instr_predecoder
  import pdec_pkg::*;
#(
  parameter int PC_W  = 24,
  parameter int IMM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_cls,
  output logic [1:0]        out_amode,
  output logic [4:0]        out_dst_reg,
  output logic [4:0]        out_src_reg,
  output logic [IMM_W-1:0]  out_imm_zext,
  output logic [IMM_W-1:0]  out_imm_sext,
  output logic [4:0]        out_ind_mod,
  output logic [2:0]        out_ind_ar,
  output logic [7:0]        out_ind_disp,
  output logic [4:0]        out_lo_mod,
  output logic [2:0]        out_lo_ar,
  output logic [4:0]        out_hi_mod,
  output logic [2:0]        out_hi_ar,
  output logic              out_page_load,
  output logic [23:0]       out_page_val,
  output logic [1:0]        out_par_route,
  output logic [1:0]        out_par_dst_a,
  output logic [1:0]        out_par_dst_b,
  output logic [2:0]        out_br_kind,
  output logic [4:0]        out_trap_vec,
  output logic [2:0]        out_dec_ar,
  output logic              out_tgt_valid,
  output logic [PC_W-1:0]   out_tgt
);
  iclass_e           cls_d;
  brkind_e           kind_d;
  logic [1:0]        amode_d, route_d, dst_a_d, dst_b_d;
  logic [REG_W-1:0]  dst_d, src_d;
  logic [IMM_W-1:0]  immz_d, imms_d;
  logic [MOD_W-1:0]  imod_d;
  logic [AR_W-1:0]   iar_d, dec_ar_d;
  logic [DISP_W-1:0] idisp_d;
  ind_short_t        lo_d, hi_d;
  logic              page_d, tgt_v_d;
  logic [PAGE_W-1:0] page_val_d;
  logic [PC_W-1:0]   tgt_d;
  logic [VEC_W-1:0]  trap_d;
  logic              accept;

  pdec_class u_class (
    .prefix (in_word[31:29]),
    .cls    (cls_d)
  );

  pdec_operand #(.IMM_W(IMM_W)) u_operand (
    .word         (in_word),
    .is_par_store (cls_d == CLS_PAR_STORE),
    .amode        (amode_d),
    .dst_reg      (dst_d),
    .src_reg      (src_d),
    .imm_zext     (immz_d),
    .imm_sext     (imms_d),
    .ind_mod      (imod_d),
    .ind_ar       (iar_d),
    .ind_disp     (idisp_d),
    .lo_ind       (lo_d),
    .hi_ind       (hi_d),
    .page_load    (page_d),
    .page_val     (page_val_d),
    .par_route    (route_d),
    .par_dst_a    (dst_a_d),
    .par_dst_b    (dst_b_d)
  );

  pdec_branch #(.PC_W(PC_W)) u_branch (
    .bits      (in_word[28:0]),
    .pc        (in_pc),
    .is_branch (cls_d == CLS_BRANCH),
    .kind      (kind_d),
    .tgt_valid (tgt_v_d),
    .tgt       (tgt_d),
    .trap_vec  (trap_d),
    .dec_ar    (dec_ar_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  // Payload has no reset: it is only looked at while out_valid is set.
  always_ff @(posedge clk) begin
    if (accept) begin
      out_cls       <= cls_d;
      out_amode     <= amode_d;
      out_dst_reg   <= dst_d;
      out_src_reg   <= src_d;
      out_imm_zext  <= immz_d;
      out_imm_sext  <= imms_d;
      out_ind_mod   <= imod_d;
      out_ind_ar    <= iar_d;
      out_ind_disp  <= idisp_d;
      out_lo_mod    <= lo_d.modf;
      out_lo_ar     <= lo_d.ar;
      out_hi_mod    <= hi_d.modf;
      out_hi_ar     <= hi_d.ar;
      out_page_load <= page_d;
      out_page_val  <= page_val_d;
      out_par_route <= route_d;
      out_par_dst_a <= dst_a_d;
      out_par_dst_b <= dst_b_d;
      out_br_kind   <= kind_d;
      out_trap_vec  <= trap_d;
      out_dec_ar    <= dec_ar_d;
      out_tgt_valid <= tgt_v_d;
      out_tgt       <= tgt_d;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cls) &&
      $stable(out_imm_zext) && $stable(out_tgt) && $stable(out_br_kind)));

  // R12
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R13
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  tgt_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tgt_valid) |-> (out_cls == CLS_BRANCH));

  // R6
  page_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_page_load) |-> (out_cls == CLS_TWO_OP && out_amode == 2'b11));

  // R11
  par_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cls != CLS_PAR_STORE) |-> (out_par_dst_b == 2'b00));
endmodule

// File: tb/instr_predecoder_tb.sv
`timescale 1ns/1ps
module instr_predecoder_tb;
  localparam int PC_W  = 24;
  localparam int IMM_W = 32;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic [PC_W-1:0] in_pc = '0;
  logic in_ready, out_valid;
  logic [2:0] out_cls, out_ind_ar, out_lo_ar, out_hi_ar, out_br_kind, out_dec_ar;
  logic [1:0] out_amode, out_par_route, out_par_dst_a, out_par_dst_b;
  logic [4:0] out_dst_reg, out_src_reg, out_ind_mod, out_lo_mod, out_hi_mod, out_trap_vec;
  logic [IMM_W-1:0] out_imm_zext, out_imm_sext;
  logic [7:0] out_ind_disp;
  logic out_page_load, out_tgt_valid;
  logic [23:0] out_page_val;
  logic [PC_W-1:0] out_tgt;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  instr_predecoder #(.PC_W(PC_W), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_cls(out_cls), .out_amode(out_amode), .out_dst_reg(out_dst_reg),
    .out_src_reg(out_src_reg), .out_imm_zext(out_imm_zext), .out_imm_sext(out_imm_sext),
    .out_ind_mod(out_ind_mod), .out_ind_ar(out_ind_ar), .out_ind_disp(out_ind_disp),
    .out_lo_mod(out_lo_mod), .out_lo_ar(out_lo_ar), .out_hi_mod(out_hi_mod),
    .out_hi_ar(out_hi_ar), .out_page_load(out_page_load), .out_page_val(out_page_val),
    .out_par_route(out_par_route), .out_par_dst_a(out_par_dst_a),
    .out_par_dst_b(out_par_dst_b), .out_br_kind(out_br_kind),
    .out_trap_vec(out_trap_vec), .out_dec_ar(out_dec_ar),
    .out_tgt_valid(out_tgt_valid), .out_tgt(out_tgt)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic check_vec(input logic [31:0] w, input logic [PC_W-1:0] pc);
    logic [2:0] e_cls, e_bk, sk;
    logic e_tv, e_pg;
    logic [PC_W-1:0] e_tgt;
    if (w[31]) e_cls = w[30] ? 3'd4 : 3'd3;
    else if (w[30:29] == 2'b01) e_cls = 3'd1;
    else if (w[30:29] == 2'b11) e_cls = 3'd2;
    else e_cls = 3'd0;
    cmp("R1 class", 32'(out_cls), 32'(e_cls));
    cmp("R2 amode", 32'(out_amode), 32'(w[22:21]));
    cmp("R2 dst", 32'(out_dst_reg), 32'(w[20:16]));
    cmp("R2 src", 32'(out_src_reg), 32'(w[4:0]));
    cmp("R3 zext", out_imm_zext, {16'h0, w[15:0]});
    cmp("R3 sext", out_imm_sext, {{16{w[15]}}, w[15:0]});
    cmp("R4 wide", {16'h0, out_ind_mod, out_ind_ar, out_ind_disp}, {16'h0, w[15:0]});
    cmp("R5 short lo", 32'({out_lo_mod, out_lo_ar}), 32'(w[7:0]));
    cmp("R5 short hi", 32'({out_hi_mod, out_hi_ar}), 32'(w[15:8]));
    e_pg = (w[31:8] == 24'h087000);
    cmp("R6 page flag", 32'(out_page_load), 32'(e_pg));
    cmp("R6 page value", 32'(out_page_val), e_pg ? 32'(w[7:0]) << 16 : 32'h0);
    e_bk = 3'd0;
    if (e_cls == 3'd2) begin
      sk = w[28:26];
      if (sk <= 3'd1) e_bk = 3'd1;
      else if (sk == 3'd2) e_bk = 3'd2;
      else if (sk == 3'd3) e_bk = 3'd3;
      else if (sk <= 3'd5) e_bk = 3'd4;
      else e_bk = 3'd5;
    end
    cmp("R7 kind", 32'(out_br_kind), 32'(e_bk));
    e_tv = (e_bk == 3'd1) || ((e_bk == 3'd2 || e_bk == 3'd3) && w[25]);
    if (!e_tv) e_tgt = '0;
    else if (e_bk == 3'd1) e_tgt = w[23:0];
    else e_tgt = pc + 24'd1 + {{8{w[15]}}, w[15:0]} + (w[21] ? 24'd2 : 24'd0);
    cmp("R9 target valid", 32'(out_tgt_valid), 32'(e_tv));
    cmp(e_bk == 3'd1 ? "R8 abs target" : "R9 rel target", 32'(out_tgt), 32'(e_tgt));
    cmp("R10 trap", 32'(out_trap_vec), e_bk == 3'd4 ? 32'(w[4:0]) : 32'h0);
    cmp("R10 dec ar", 32'(out_dec_ar), e_bk == 3'd3 ? 32'(w[24:22]) : 32'h0);
    cmp("R11 route", 32'(out_par_route), e_cls == 3'd4 ? 32'(w[25:24]) : 32'h0);
    cmp("R11 dst a", 32'(out_par_dst_a), e_cls == 3'd4 ? 32'(w[23]) : 32'h0);
    cmp("R11 dst b", 32'(out_par_dst_b), e_cls == 3'd4 ? 32'({1'b1, w[22]}) : 32'h0);
  endtask

  task automatic apply(input logic [31:0] w, input logic [PC_W-1:0] pc);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_pc    = pc;
    @(negedge clk);
    in_valid = 1'b0;
    cmp("R12 valid after accept", 32'(out_valid), 32'd1);
    check_vec(w, pc);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] wa, wb;
    repeat (3) @(negedge clk);
    cmp("R13 reset valid", 32'(out_valid), 32'd0);
    cmp("R12 ready in reset", 32'(in_ready), 32'd1);
    rst = 1'b0;

    // R1 R2 R3 R4 R5: every prefix with scattered lower bits
    for (int top = 0; top < 8; top++)
      for (int k = 0; k < 40; k++)
        apply({3'(top), next_rand()[28:0]}, next_rand()[PC_W-1:0]);

    // R6: full page-byte sweep and near misses
    for (int b = 0; b < 256; b++) apply(32'h0870_0000 | 32'(b), 24'h0);
    apply(32'h0870_0100, 24'h0);
    apply(32'h0860_00FF, 24'h0);
    apply(32'h0970_0001, 24'h0);

    // R7 R8 R9 R10: branch sub-kinds, flags, offset and PC corners
    for (int sk = 0; sk < 8; sk++)
      for (int fl = 0; fl < 4; fl++)
        for (int oi = 0; oi < 6; oi++)
          for (int pi = 0; pi < 3; pi++) begin
            logic [15:0] off;
            logic [PC_W-1:0] pcv;
            logic [31:0] r;
            case (oi)
              0: off = 16'h0000; 1: off = 16'h0001; 2: off = 16'h7FFF;
              3: off = 16'h8000; 4: off = 16'hFFFF; default: off = 16'hFFFE;
            endcase
            case (pi)
              0: pcv = 24'h000000; 1: pcv = 24'hFFFFFF; default: pcv = 24'h123456;
            endcase
            r = next_rand();
            apply({3'b011, 3'(sk), fl[1], r[2:0], fl[0], r[7:3], off}, pcv);
          end

    // R11: every routing and destination pattern of the parallel-store class
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] r;
        r = next_rand();
        apply({2'b11, r[29:26], 4'(p), r[21:0]}, 24'h0);
      end

    // R12: stall holds the result and blocks the next word
    wa = 32'h6000_ABCD;
    wb = 32'h0870_0042;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_word = wa; in_pc = 24'h000010;
    @(negedge clk);
    cmp("R12 ready low on stall", 32'(in_ready), 32'd0);
    in_word = wb; in_pc = 24'h000020;
    @(negedge clk);
    cmp("R12 valid held", 32'(out_valid), 32'd1);
    check_vec(wa, 24'h000010);
    @(negedge clk);
    check_vec(wa, 24'h000010);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(wb, 24'h000020);
    @(negedge clk);
    cmp("R12 valid drops when idle", 32'(out_valid), 32'd0);

    // R13: reset with a pending result
    out_ready = 1'b0;
    apply(32'h2000_0000, 24'h0);
    rst = 1'b1;
    @(negedge clk);
    cmp("R13 reset clears pending", 32'(out_valid), 32'd0);
    rst = 1'b0;
    out_ready = 1'b1;

    // mixed random words
    for (int k = 0; k < 400; k++) apply(next_rand(), next_rand()[PC_W-1:0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule